// File: doc/BRIEF.md
# Fractional Rate Scaler

This block turns a sampled input clock into a stream of one-cycle event strobes whose long-term rate is the input edge rate divided by an integer P and then multiplied by an exact ratio N/D, with N below D. It serves as the front end of a reference path. Its purpose is to remove the rate changes that line coding or forward error correction add, such as 64/66 or 238/255, before the reference is selected. All logic runs in one system clock domain. The input clock level is sampled there. Either its rising or its falling transitions count as events, chosen by a polarity control.

Each event that survives the integer predivider adds N to an accumulator. When the total reaches D, the block subtracts D and emits one output strobe. The ratio is therefore exact, and no error builds up over time. An illegal ratio suppresses all output and raises a registered error flag. Any change of the ratio, the predivider or the polarity restarts the scaler from zero phase. A synchronous clear input does the same.

Top module: `frac_rate_scaler`

## Requirements
- R1: An input event is a 0-to-1 transition of `ref_i` XOR `invert_i`. With `invert_i`=0 only rising edges of `ref_i` count, and with `invert_i`=1 only falling edges count. A transition in the other direction produces nothing.
- R2: With `pdiv_i` equal to 0 or 1, every input event is forwarded to the scaler. With `pdiv_i`=P≥2, only the P-th, 2P-th, 3P-th, … events counted from zero phase are forwarded.
- R3: Each forwarded event adds `num_i` to an accumulator that starts at zero. When the sum is at least `den_i`, `den_i` is subtracted and `evt_o` is high for exactly one cycle. That cycle is the one after the clock edge at which the active input level is first sampled.
- R4: Counting from zero phase, the j-th forwarded event produces an output exactly when floor(j·N/D) > floor((j−1)·N/D). After F forwarded events the output count is therefore floor(F·N/D).
- R5: `evt_o` is never high except in the cycle after a forwarded event, and it gives at most one strobe per forwarded event.
- R6: `cfg_err_o` is high, one cycle after the configuration is applied, when `den_i`=0 or when `num_i`≥`den_i`, except for the case `num_i`=`den_i`=1. While it is high `evt_o` stays low.
- R7: With `num_i`=`den_i`=1 the scaler is bypassed and every forwarded event produces an output strobe.
- R8: A change of `num_i`, `den_i`, `pdiv_i` or `invert_i` returns the accumulator and the predivider count to zero phase. An event in the cycle of the change is dropped.
- R9: `clr_i` high for one cycle returns the accumulator and the predivider count to zero phase. An event sampled in that cycle is dropped and produces no output.
- R10: While `rst_ni` is low, `evt_o` and `cfg_err_o` are both 0.
- R11: With `num_i`=0 and a nonzero `den_i`, no output is ever produced and `cfg_err_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous restart to zero phase |
| ref_i | input | 1 | Input clock level, sampled in the clk_i domain |
| invert_i | input | 1 | 1 selects falling edges of ref_i as events |
| pdiv_i | input | PDIV_W (8) | Integer predivider; 0 and 1 mean divide by one |
| num_i | input | NUM_W (16) | Ratio numerator N |
| den_i | input | DEN_W (32) | Ratio denominator D |
| evt_o | output | 1 | Scaled event strobe, one cycle wide |
| cfg_err_o | output | 1 | Illegal ratio flag, registered |

## Verification
The bench builds the block with its default widths: a 16-bit numerator, a 32-bit denominator and an 8-bit predivider. These widths let it run the coding ratios 64/66 and 23x/255 over whole periods. They also cover the extremes 65535/65536 and 1/(2^32−1), where the accumulator runs close to its full 33-bit range. The 8-bit predivider makes divide-by-2 and divide-by-3 reachable in combination with either polarity. Illegal ratios, bypass, a zero numerator, clears that land on an edge, and mid-stream ratio changes are driven directly. Every output strobe is compared against the floor formula.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int FRS_NUM_W  = 16;
  localparam int FRS_DEN_W  = 32;
  localparam int FRS_PDIV_W = 8;

  typedef enum logic [1:0] {
    FRS_OK     = 2'd0,
    FRS_BYPASS = 2'd1,
    FRS_ERR    = 2'd2
  } frs_mode_e;
endpackage

// File: rtl/frs_edge_cond.sv
module frs_edge_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic ref_i,
  input  logic invert_i,
  output logic edge_o
);
  logic lvl, lvl_q;

  assign lvl    = ref_i ^ invert_i;
  assign edge_o = lvl & ~lvl_q & ~clear_i;

  // reset high: a level already active after reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl;
  end

  // R1
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/frs_predivider.sv
module frs_predivider #(
  parameter int PDIV_W = frs_pkg::FRS_PDIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              evt_i,
  input  logic [PDIV_W-1:0] pdiv_i,
  output logic              evt_o
);
  logic [PDIV_W-1:0] cnt_q;
  logic              pass;
  logic              wrap;

  assign pass  = (pdiv_i <= PDIV_W'(1));
  assign wrap  = (cnt_q == pdiv_i - PDIV_W'(1));
  assign evt_o = evt_i & ~clear_i & (pass | wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i || pass)  cnt_q <= '0;
    else if (evt_i)            cnt_q <= wrap ? '0 : cnt_q + PDIV_W'(1);
  end

  // R2
  pdiv_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass && !clear_i) |-> (cnt_q < pdiv_i));
endmodule

// File: rtl/frs_cfg_guard.sv
module frs_cfg_guard
  import frs_pkg::*;
#(
  parameter int NUM_W  = FRS_NUM_W,
  parameter int DEN_W  = FRS_DEN_W,
  parameter int PDIV_W = FRS_PDIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [DEN_W-1:0]  den_i,
  input  logic [PDIV_W-1:0] pdiv_i,
  input  logic              invert_i,
  output logic              clear_o,
  output frs_mode_e         mode_o,
  output logic              err_o
);
  localparam int CFG_W = NUM_W + DEN_W + PDIV_W + 1;

  logic [CFG_W-1:0] cfg, cfg_q;
  logic [DEN_W-1:0] num_ext;

  assign cfg     = {num_i, den_i, pdiv_i, invert_i};
  assign num_ext = DEN_W'(num_i);
  assign clear_o = clr_i | (cfg != cfg_q);

  always_comb begin
    if (den_i == '0)                                      mode_o = FRS_ERR;
    else if (num_ext == DEN_W'(1) && den_i == DEN_W'(1))  mode_o = FRS_BYPASS;
    else if (num_ext >= den_i)                            mode_o = FRS_ERR;
    else                                                  mode_o = FRS_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_o <= 1'b0;
    end else begin
      cfg_q <= cfg;
      err_o <= (mode_o == FRS_ERR);
    end
  end

  // R8
  cfg_change_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg) |-> clear_o);
endmodule

// File: rtl/frs_accum.sv
module frs_accum
  import frs_pkg::*;
#(
  parameter int NUM_W = FRS_NUM_W,
  parameter int DEN_W = FRS_DEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  frs_mode_e        mode_i,
  input  logic             evt_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             evt_o
);
  logic [DEN_W-1:0] acc_q;
  logic [DEN_W:0]   sum;
  logic             hit;

  // acc < D and N < D, so sum < 2D fits in DEN_W+1 bits
  assign sum = {1'b0, acc_q} + (DEN_W + 1)'(num_i);
  assign hit = (sum >= {1'b0, den_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      evt_o <= 1'b0;
    end else if (clear_i || mode_i != FRS_OK) begin
      acc_q <= '0;
      evt_o <= evt_i && !clear_i && (mode_i == FRS_BYPASS);
    end else if (evt_i) begin
      acc_q <= hit ? DEN_W'(sum - {1'b0, den_i}) : sum[DEN_W-1:0];
      evt_o <= hit;
    end else begin
      evt_o <= 1'b0;
    end
  end

  // R3
  acc_below_den_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FRS_OK && !clear_i) |-> (acc_q < den_i));

  // R9
  clear_no_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !evt_o);
endmodule

// File: rtl/frac_rate_scaler.sv
module frac_rate_scaler
  import frs_pkg::*;
#(
  parameter int NUM_W  = FRS_NUM_W,
  parameter int DEN_W  = FRS_DEN_W,
  parameter int PDIV_W = FRS_PDIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ref_i,
  input  logic              invert_i,
  input  logic [PDIV_W-1:0] pdiv_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [DEN_W-1:0]  den_i,
  output logic              evt_o,
  output logic              cfg_err_o
);
  logic      clear;
  logic      edge_evt;
  logic      div_evt;
  frs_mode_e mode;

  frs_cfg_guard #(.NUM_W(NUM_W), .DEN_W(DEN_W), .PDIV_W(PDIV_W)) u_guard (
    .clk_i, .rst_ni, .clr_i, .num_i, .den_i, .pdiv_i, .invert_i,
    .clear_o(clear), .mode_o(mode), .err_o(cfg_err_o)
  );

  frs_edge_cond u_edge (
    .clk_i, .rst_ni, .clear_i(clear), .ref_i, .invert_i, .edge_o(edge_evt)
  );

  frs_predivider #(.PDIV_W(PDIV_W)) u_pdiv (
    .clk_i, .rst_ni, .clear_i(clear), .evt_i(edge_evt), .pdiv_i, .evt_o(div_evt)
  );

  frs_accum #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_acc (
    .clk_i, .rst_ni, .clear_i(clear), .mode_i(mode), .evt_i(div_evt),
    .num_i, .den_i, .evt_o
  );

  // R5
  out_needs_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(div_evt));

  // R6
  err_blocks_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !evt_o);

  // R10
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!evt_o && !cfg_err_o));
endmodule

// File: tb/frac_rate_scaler_tb_top.sv
module frac_rate_scaler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        ref_lvl = 1'b0;
  logic        inv = 1'b0;
  logic [7:0]  pdiv = 8'd1;
  logic [15:0] num = 16'd0;
  logic [31:0] den = 32'd1;
  logic        evt_o, cfg_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  longint m_j, m_pcnt, m_outs;
  longint m_n, m_d, m_p;
  bit     m_err;

  always #2 clk = ~clk;

  frac_rate_scaler dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .ref_i(ref_lvl), .invert_i(inv),
    .pdiv_i(pdiv), .num_i(num), .den_i(den), .evt_o(evt_o), .cfg_err_o(cfg_err_o)
  );

  localparam int NV = 12;
  localparam longint T_N [NV] = '{64, 238, 237, 236, 1, 0, 3, 65535, 5, 9, 3, 1};
  localparam longint T_D [NV] = '{66, 255, 255, 255, 1, 5, 7, 65536, 5, 4, 0, 64'd4294967295};
  localparam longint T_P [NV] = '{1, 1, 2, 0, 1, 1, 3, 1, 1, 1, 1, 1};
  localparam bit     T_I [NV] = '{0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1};
  localparam int     T_E [NV] = '{132, 255, 510, 255, 12, 10, 42, 40, 6, 6, 6, 20};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_restart();
    m_j = 0; m_pcnt = 0; m_outs = 0;
  endtask

  task automatic apply_cfg(input longint n, input longint d, input longint p, input bit i);
    @(negedge clk);
    inv = i; ref_lvl = i;  // idle level
    num = n[15:0]; den = d[31:0]; pdiv = p[7:0];
    m_n = n; m_d = d; m_p = p;
    m_err = (d == 0) || ((n >= d) && !(n == 1 && d == 1));
    @(negedge clk); @(negedge clk);
    model_restart();
  endtask

  function automatic bit model_step();
    bit fwd;
    longint a, b;
    if (m_p <= 1) fwd = 1;
    else begin
      m_pcnt++;
      fwd = (m_pcnt == m_p);
      if (fwd) m_pcnt = 0;
    end
    if (!fwd || m_err) return 0;
    m_j++;
    a = (m_j * m_n) / m_d;
    b = ((m_j - 1) * m_n) / m_d;
    return a != b;
  endfunction

  task automatic pulse(input string req);
    bit exp;
    @(negedge clk); ref_lvl = ~inv;
    @(negedge clk); ref_lvl = inv;
    exp = model_step();
    if (exp) m_outs++;
    chk(evt_o == exp, req, evt_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(evt_o == 0, "R10 evt_o in reset", evt_o, 0);
    chk(cfg_err_o == 0, "R10 cfg_err_o in reset", cfg_err_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // table walk: R2 R3 R4 R6 R7 R11
    for (int v = 0; v < NV; v++) begin
      apply_cfg(T_N[v], T_D[v], T_P[v], T_I[v]);
      chk(cfg_err_o == m_err, "R6 cfg_err_o", cfg_err_o, m_err);
      for (int e = 0; e < T_E[v]; e++) pulse("R3 R4 evt_o per event");
      if (!m_err && m_d != 0)
        chk(m_outs == (m_j * m_n) / m_d, "R4 total count", m_outs, (m_j * m_n) / m_d);
    end

    // R1: opposite-direction transition is not an event
    apply_cfg(1, 1, 1, 0);
    @(negedge clk); ref_lvl = 1'b1;
    @(negedge clk);
    chk(evt_o == 1, "R1 rising edge counts", evt_o, 1);
    @(negedge clk);
    chk(evt_o == 0, "R7 single strobe", evt_o, 0);
    ref_lvl = 1'b0;
    @(negedge clk);
    chk(evt_o == 0, "R1 falling edge ignored", evt_o, 0);
    @(negedge clk);
    chk(evt_o == 0, "R1 falling edge ignored late", evt_o, 0);

    // R9: clear mid-stream restarts phase (3/7: outputs at j=3,5,7)
    apply_cfg(3, 7, 1, 0);
    for (int e = 0; e < 4; e++) pulse("R3 before clear");
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_restart();
    for (int e = 0; e < 7; e++) pulse("R9 after clear");

    // R9: clear coinciding with an edge drops it
    for (int e = 0; e < 2; e++) pulse("R9 pre");
    @(negedge clk); clr = 1'b1; ref_lvl = 1'b1;
    @(negedge clk); clr = 1'b0; ref_lvl = 1'b0;
    chk(evt_o == 0, "R9 edge during clear dropped", evt_o, 0);
    model_restart();
    for (int e = 0; e < 3; e++) pulse("R9 phase zero");

    // R8: ratio and predivider change restarts phase
    apply_cfg(3, 7, 3, 0);
    for (int e = 0; e < 5; e++) pulse("R2 predivide");
    apply_cfg(4, 7, 2, 0);
    for (int e = 0; e < 8; e++) pulse("R8 after change");
    chk(cfg_err_o == 0, "R11 cfg_err_o low on legal ratio", cfg_err_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule